// File: doc/BRIEF.md
# Set-Associative Cache Lookup Controller

A small read/write cache that sits between a processor request port and a word-addressed backing memory. Each request is accepted when the block is idle. The block indexes one set, compares every way's tag against the request at the same time, and either answers from the cache or runs the memory traffic needed to complete the access. Memory traffic is handled one word per request/acknowledge handshake. It covers line refills, write-back of modified victims and single-word writes.

The write policy is fixed at elaboration by the `WRITE_BACK` parameter. When it is non-zero, writes stay in the cache and mark the line modified, and a write miss first brings the line in. When it is zero, every write goes to memory as one word, and a write miss leaves the cache untouched. The block does not choose which way to replace. An external selector supplies the way on `victim_way`, and the controller samples it in the cycle it detects a miss.

Top module: `cache_lookup_ctrl`

## Requirements
- R1: A word address splits into an offset (low `OFF_W` bits, selecting one of 2^`OFF_W` words in a line), a set index (next `SET_W` bits) and a tag (remaining bits); addresses that differ only in offset share one line.
- R2: After reset every line is invalid and clean, `req_ready` is 1, and both `resp_valid` and `mem_req` are 0.
- R3: A request hits when some way of the indexed set is valid and holds the request tag; at most one way matches. A read hit returns the stored word with `resp_hit`=1 in the cycle after the lookup cycle.
- R4: On a read miss the line is fetched one word at a time into the way named by `victim_way`, and the response carries the requested word with `resp_hit`=0. Exactly 2^`OFF_W` memory reads occur.
- R5: `req_ready` is 0 from the cycle after acceptance until the response. `resp_valid` is a one-cycle pulse, and `req_ready` is 1 during that pulse.
- R6: While `mem_req` is 1 and `mem_ack` is 0, `mem_req`, `mem_we`, `mem_addr` and `mem_wdata` hold their values. Each acknowledge moves one word.
- R7: Write-back mode: a write hit updates only the cached word and marks the line modified. Memory is not written, and a later read returns the new word.
- R8: Write-back mode: replacing a modified line first writes all of its words to memory. Replacing a clean line writes nothing.
- R9: Write-back mode: a write miss refills the line (`resp_hit`=0), then writes the word into it. A later read of that address hits.
- R10: Write-through mode: every write performs one memory word write to the request address before the response. A write hit also updates the cached copy.
- R11: Write-through mode: a write miss performs no memory read and installs no line, so a later read of that address misses.
- R12: With least-recently-used victims and 4-word lines, the read sequence 0, 1, 49, 32, 0 (all set 0, three distinct lines) yields miss, hit, miss, miss, miss.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Processor request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address of the request |
| req_wdata | input | DATA_W | Write data |
| req_ready | output | 1 | Controller idle, request accepted this cycle if valid |
| resp_valid | output | 1 | One-cycle completion pulse |
| resp_rdata | output | DATA_W | Read data (zero for writes) |
| resp_hit | output | 1 | Request was served without a miss |
| victim_way | input | WAY_W | Way to replace, from the external selector |
| mem_req | output | 1 | Memory word transfer pending |
| mem_we | output | 1 | Transfer is a write |
| mem_addr | output | ADDR_W | Memory word address |
| mem_wdata | output | DATA_W | Memory write data |
| mem_ack | input | 1 | Memory completes the current word |
| mem_rdata | input | DATA_W | Memory read data, valid with `mem_ack` |

## Verification
Directed sequences are run first. A conflict-heavy read trace in one set separates correct tag compare and victim placement from an off-by-one in the address split. Paired clean and modified evictions show whether write-back is gated by the modified bit. Write hits and misses are then issued in both policy instances, with memory word counters that separate allocation from write-around. After that, a long seeded random mix of reads and writes over a small address range forces frequent conflicts. Every response is compared against a bench model of tags, LRU age and memory contents, so a lost write-back, stale refill or wrong hit flag shows up as a data or hit mismatch.

// File: rtl/cache_pkg.sv
package cache_pkg;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_LOOKUP = 3'd1,
        ST_EVICT  = 3'd2,
        ST_FILL   = 3'd3,
        ST_WORD   = 3'd4
    } cache_state_e;

endpackage

// File: rtl/cache_tag_store.sv
module cache_tag_store #(
    parameter int SET_W = 2,
    parameter int TAG_W = 6,
    parameter int WAYS  = 2,
    parameter int WAY_W = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SET_W-1:0] lk_set,
    input  logic [TAG_W-1:0] lk_tag,
    output logic             hit,
    output logic [WAY_W-1:0] hit_way,
    input  logic [WAY_W-1:0] vic_way,
    output logic             vic_valid,
    output logic             vic_dirty,
    output logic [TAG_W-1:0] vic_tag,
    input  logic             wr_en,
    input  logic [WAY_W-1:0] wr_way,
    input  logic             wr_dirty
);
    localparam int SETS = 1 << SET_W;

    logic [WAYS-1:0]  valid_q [SETS];
    logic [WAYS-1:0]  valid_d [SETS];
    logic [WAYS-1:0]  dirty_q [SETS];
    logic [WAYS-1:0]  dirty_d [SETS];
    logic [TAG_W-1:0] tag_q   [SETS][WAYS];
    logic [TAG_W-1:0] tag_d   [SETS][WAYS];
    logic [WAYS-1:0]  match;

    // parallel compare, one comparator per way
    for (genvar w = 0; w < WAYS; w++) begin : g_cmp
        assign match[w] = valid_q[lk_set][w] && (tag_q[lk_set][w] == lk_tag);
    end

    assign hit = |match;

    always_comb begin
        hit_way = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (match[w]) hit_way = WAY_W'(w);
        end
    end

    assign vic_valid = valid_q[lk_set][vic_way];
    assign vic_dirty = dirty_q[lk_set][vic_way];
    assign vic_tag   = tag_q[lk_set][vic_way];

    always_comb begin
        valid_d = valid_q;
        dirty_d = dirty_q;
        tag_d   = tag_q;
        if (wr_en) begin
            valid_d[lk_set][wr_way] = 1'b1;
            dirty_d[lk_set][wr_way] = wr_dirty;
            tag_d[lk_set][wr_way]   = lk_tag;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) begin
                valid_q[s] <= '0;
                dirty_q[s] <= '0;
                for (int w = 0; w < WAYS; w++) tag_q[s][w] <= '0;
            end
        end else begin
            valid_q <= valid_d;
            dirty_q <= dirty_d;
            tag_q   <= tag_d;
        end
    end

    // duplicate installs of one tag would make two ways match
    assert_one_way_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(match));

endmodule

// File: rtl/cache_data_store.sv
module cache_data_store #(
    parameter int SET_W  = 2,
    parameter int OFF_W  = 2,
    parameter int WAYS   = 2,
    parameter int WAY_W  = 1,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic [SET_W-1:0]  set_idx,
    input  logic [WAY_W-1:0]  rd_way,
    input  logic [OFF_W-1:0]  rd_word,
    output logic [DATA_W-1:0] rd_data,
    input  logic              wr_en,
    input  logic [WAY_W-1:0]  wr_way,
    input  logic [OFF_W-1:0]  wr_word,
    input  logic [DATA_W-1:0] wr_data
);
    localparam int SETS    = 1 << SET_W;
    localparam int WORDS   = 1 << OFF_W;
    localparam int ENTRIES = SETS * WAYS * WORDS;
    localparam int IDX_W   = $clog2(ENTRIES);

    logic [DATA_W-1:0] mem_q [ENTRIES];
    logic [DATA_W-1:0] mem_d [ENTRIES];

    function automatic logic [IDX_W-1:0] flat(input logic [SET_W-1:0] s,
                                              input logic [WAY_W-1:0] w,
                                              input logic [OFF_W-1:0] o);
        return IDX_W'((int'(s) * WAYS + int'(w)) * WORDS + int'(o));
    endfunction

    assign rd_data = mem_q[flat(set_idx, rd_way, rd_word)];

    always_comb begin
        mem_d = mem_q;
        if (wr_en) mem_d[flat(set_idx, wr_way, wr_word)] = wr_data;
    end

    always_ff @(posedge clk) begin
        mem_q <= mem_d;
    end

endmodule

// File: rtl/cache_ctrl_fsm.sv
module cache_ctrl_fsm
    import cache_pkg::*;
#(
    parameter int ADDR_W     = 10,
    parameter int DATA_W     = 32,
    parameter int OFF_W      = 2,
    parameter int SET_W      = 2,
    parameter int WAY_W      = 1,
    parameter int WRITE_BACK = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              req_ready,
    output logic              resp_valid,
    output logic [DATA_W-1:0] resp_rdata,
    output logic              resp_hit,
    input  logic [WAY_W-1:0]  victim_way,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic              mem_ack,
    input  logic [DATA_W-1:0] mem_rdata,
    // tag store side
    output logic [SET_W-1:0]  lk_set,
    output logic [ADDR_W-SET_W-OFF_W-1:0] lk_tag,
    input  logic              hit,
    input  logic [WAY_W-1:0]  hit_way,
    output logic [WAY_W-1:0]  vic_way_sel,
    input  logic              vic_valid,
    input  logic              vic_dirty,
    input  logic [ADDR_W-SET_W-OFF_W-1:0] vic_tag,
    output logic              tag_we,
    output logic [WAY_W-1:0]  tag_way,
    output logic              tag_dirty,
    // data store side
    output logic [WAY_W-1:0]  dat_rd_way,
    output logic [OFF_W-1:0]  dat_rd_word,
    input  logic [DATA_W-1:0] rd_data,
    output logic              dat_we,
    output logic [WAY_W-1:0]  dat_way,
    output logic [OFF_W-1:0]  dat_word,
    output logic [DATA_W-1:0] dat_wdata
);
    localparam int TAG_W = ADDR_W - SET_W - OFF_W;

    typedef struct packed {
        cache_state_e      state;
        logic [ADDR_W-1:0] addr;
        logic              write;
        logic [DATA_W-1:0] wdata;
        logic [WAY_W-1:0]  way;
        logic [OFF_W-1:0]  cnt;
        logic              missed;
        logic              resp_valid;
        logic              resp_hit;
        logic [DATA_W-1:0] resp_rdata;
    } ctrl_t;

    ctrl_t q, n;

    logic [OFF_W-1:0] offset;

    assign offset = q.addr[OFF_W-1:0];
    assign lk_set = q.addr[OFF_W +: SET_W];
    assign lk_tag = q.addr[ADDR_W-1 -: TAG_W];

    assign req_ready  = (q.state == ST_IDLE);
    assign resp_valid = q.resp_valid;
    assign resp_rdata = q.resp_rdata;
    assign resp_hit   = q.resp_hit;

    assign vic_way_sel = (q.state == ST_LOOKUP) ? victim_way : q.way;
    assign dat_rd_way  = (q.state == ST_EVICT) ? q.way : hit_way;
    assign dat_rd_word = (q.state == ST_EVICT) ? q.cnt : offset;

    // memory port, driven from registered state only
    always_comb begin
        mem_req   = (q.state == ST_EVICT) || (q.state == ST_FILL) || (q.state == ST_WORD);
        mem_we    = (q.state == ST_EVICT) || (q.state == ST_WORD);
        mem_wdata = (q.state == ST_EVICT) ? rd_data : q.wdata;
        unique case (q.state)
            ST_EVICT: mem_addr = {vic_tag, lk_set, q.cnt};
            ST_FILL:  mem_addr = {lk_tag, lk_set, q.cnt};
            default:  mem_addr = q.addr;
        endcase
    end

    always_comb begin
        n              = q;
        n.resp_valid   = 1'b0;
        tag_we         = 1'b0;
        tag_way        = hit_way;
        tag_dirty      = 1'b0;
        dat_we         = 1'b0;
        dat_way        = hit_way;
        dat_word       = offset;
        dat_wdata      = q.wdata;
        unique case (q.state)
            ST_IDLE: begin
                if (req_valid) begin
                    n.state  = ST_LOOKUP;
                    n.addr   = req_addr;
                    n.write  = req_write;
                    n.wdata  = req_wdata;
                    n.missed = 1'b0;
                end
            end
            ST_LOOKUP: begin
                if (hit) begin
                    if (!q.write) begin
                        n.resp_valid = 1'b1;
                        n.resp_hit   = !q.missed;
                        n.resp_rdata = rd_data;
                        n.state      = ST_IDLE;
                    end else begin
                        dat_we = 1'b1;
                        if (WRITE_BACK != 0) begin
                            tag_we       = 1'b1;
                            tag_dirty    = 1'b1;
                            n.resp_valid = 1'b1;
                            n.resp_hit   = !q.missed;
                            n.resp_rdata = '0;
                            n.state      = ST_IDLE;
                        end else begin
                            n.state = ST_WORD;
                        end
                    end
                end else begin
                    n.missed = 1'b1;
                    n.way    = victim_way;
                    n.cnt    = '0;
                    if (q.write && (WRITE_BACK == 0)) begin
                        n.state = ST_WORD;
                    end else if ((WRITE_BACK != 0) && vic_valid && vic_dirty) begin
                        n.state = ST_EVICT;
                    end else begin
                        n.state = ST_FILL;
                    end
                end
            end
            ST_EVICT: begin
                if (mem_ack) begin
                    n.cnt = q.cnt + 1'b1;
                    if (&q.cnt) n.state = ST_FILL;
                end
            end
            ST_FILL: begin
                dat_way   = q.way;
                dat_word  = q.cnt;
                dat_wdata = mem_rdata;
                if (mem_ack) begin
                    dat_we = 1'b1;
                    n.cnt  = q.cnt + 1'b1;
                    if (&q.cnt) begin
                        tag_we    = 1'b1;
                        tag_way   = q.way;
                        tag_dirty = 1'b0;
                        n.state   = ST_LOOKUP;
                    end
                end
            end
            ST_WORD: begin
                if (mem_ack) begin
                    n.resp_valid = 1'b1;
                    n.resp_hit   = !q.missed;
                    n.resp_rdata = '0;
                    n.state      = ST_IDLE;
                end
            end
            default: n.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= n;
    end

    assert_mem_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

    assert_resp_when_ready_R5: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |-> req_ready);

    assert_evict_only_dirty_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (q.state == ST_EVICT) |-> ((WRITE_BACK != 0) && vic_valid && vic_dirty));

    assert_refill_then_hit_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (q.state == ST_FILL && mem_ack && (&q.cnt)) |=> hit);

endmodule

// File: rtl/cache_lookup_ctrl.sv
module cache_lookup_ctrl #(
    parameter int ADDR_W     = 10,
    parameter int DATA_W     = 32,
    parameter int OFF_W      = 2,
    parameter int SET_W      = 2,
    parameter int WAYS       = 2,
    parameter int WAY_W      = (WAYS > 1) ? $clog2(WAYS) : 1,
    parameter int WRITE_BACK = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              req_ready,
    output logic              resp_valid,
    output logic [DATA_W-1:0] resp_rdata,
    output logic              resp_hit,
    input  logic [WAY_W-1:0]  victim_way,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic              mem_ack,
    input  logic [DATA_W-1:0] mem_rdata
);
    localparam int TAG_W = ADDR_W - SET_W - OFF_W;

    logic [SET_W-1:0]  lk_set;
    logic [TAG_W-1:0]  lk_tag;
    logic              hit;
    logic [WAY_W-1:0]  hit_way;
    logic [WAY_W-1:0]  vic_way_sel;
    logic              vic_valid;
    logic              vic_dirty;
    logic [TAG_W-1:0]  vic_tag;
    logic              tag_we;
    logic [WAY_W-1:0]  tag_way;
    logic              tag_dirty;
    logic [WAY_W-1:0]  dat_rd_way;
    logic [OFF_W-1:0]  dat_rd_word;
    logic [DATA_W-1:0] rd_data;
    logic              dat_we;
    logic [WAY_W-1:0]  dat_way;
    logic [OFF_W-1:0]  dat_word;
    logic [DATA_W-1:0] dat_wdata;

    cache_ctrl_fsm #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .OFF_W(OFF_W), .SET_W(SET_W),
        .WAY_W(WAY_W), .WRITE_BACK(WRITE_BACK)
    ) u_fsm (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
        .req_wdata(req_wdata), .req_ready(req_ready),
        .resp_valid(resp_valid), .resp_rdata(resp_rdata), .resp_hit(resp_hit),
        .victim_way(victim_way),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .lk_set(lk_set), .lk_tag(lk_tag), .hit(hit), .hit_way(hit_way),
        .vic_way_sel(vic_way_sel), .vic_valid(vic_valid), .vic_dirty(vic_dirty),
        .vic_tag(vic_tag), .tag_we(tag_we), .tag_way(tag_way), .tag_dirty(tag_dirty),
        .dat_rd_way(dat_rd_way), .dat_rd_word(dat_rd_word), .rd_data(rd_data),
        .dat_we(dat_we), .dat_way(dat_way), .dat_word(dat_word), .dat_wdata(dat_wdata)
    );

    cache_tag_store #(
        .SET_W(SET_W), .TAG_W(TAG_W), .WAYS(WAYS), .WAY_W(WAY_W)
    ) u_tags (
        .clk(clk), .rst_n(rst_n),
        .lk_set(lk_set), .lk_tag(lk_tag), .hit(hit), .hit_way(hit_way),
        .vic_way(vic_way_sel), .vic_valid(vic_valid), .vic_dirty(vic_dirty),
        .vic_tag(vic_tag), .wr_en(tag_we), .wr_way(tag_way), .wr_dirty(tag_dirty)
    );

    cache_data_store #(
        .SET_W(SET_W), .OFF_W(OFF_W), .WAYS(WAYS), .WAY_W(WAY_W), .DATA_W(DATA_W)
    ) u_data (
        .clk(clk), .set_idx(lk_set),
        .rd_way(dat_rd_way), .rd_word(dat_rd_word), .rd_data(rd_data),
        .wr_en(dat_we), .wr_way(dat_way), .wr_word(dat_word), .wr_data(dat_wdata)
    );

endmodule

// File: tb/cache_lookup_ctrl_bench.sv
`timescale 1ns/1ps

module cache_mem_model #(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              mem_req,
    input  logic              mem_we,
    input  logic [ADDR_W-1:0] mem_addr,
    input  logic [DATA_W-1:0] mem_wdata,
    output logic              mem_ack,
    output logic [DATA_W-1:0] mem_rdata
);
    logic [DATA_W-1:0] store [1 << ADDR_W];
    int rd_count = 0;
    int wr_count = 0;
    int viol     = 0;
    logic              pending = 1'b0;
    logic [ADDR_W-1:0] addr_r;
    logic              we_r;
    logic [DATA_W-1:0] wd_r;
    int                wait_n = 0;

    function automatic logic [DATA_W-1:0] seed_word(input int a);
        return DATA_W'(32'(a) * 32'h9E3779B1 ^ 32'h5A5A0000);
    endfunction

    initial begin
        mem_ack   = 1'b0;
        mem_rdata = '0;
        for (int a = 0; a < (1 << ADDR_W); a++) store[a] = seed_word(a);
    end

    always @(negedge clk) begin
        if (mem_ack) begin
            mem_ack = 1'b0;
            pending = 1'b0;
        end else if (mem_req) begin
            if (!pending) begin
                pending = 1'b1;
                addr_r  = mem_addr;
                we_r    = mem_we;
                wd_r    = mem_wdata;
                wait_n  = int'($urandom % 3);
            end else if (addr_r != mem_addr || we_r != mem_we || (we_r && wd_r != mem_wdata)) begin
                viol++;
            end
            if (wait_n == 0) begin
                mem_ack = 1'b1;
                if (mem_we) begin
                    store[mem_addr] = mem_wdata;
                    wr_count++;
                end else begin
                    mem_rdata = store[mem_addr];
                    rd_count++;
                end
            end else begin
                wait_n--;
            end
        end
    end
endmodule

module cache_lookup_ctrl_bench;
    localparam int AW    = 10;
    localparam int DW    = 32;
    localparam int OFF_W = 2;
    localparam int SET_W = 2;
    localparam int WAYS  = 2;
    localparam int SETS  = 1 << SET_W;
    localparam int WORDS = 1 << OFF_W;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic          req_valid  [2];
    logic          req_write  [2];
    logic [AW-1:0] req_addr   [2];
    logic [DW-1:0] req_wdata  [2];
    logic          req_ready  [2];
    logic          resp_valid [2];
    logic [DW-1:0] resp_rdata [2];
    logic          resp_hit   [2];
    logic [0:0]    victim_way [2];
    logic          mem_req    [2];
    logic          mem_we     [2];
    logic [AW-1:0] mem_addr   [2];
    logic [DW-1:0] mem_wdata  [2];
    logic          mem_ack    [2];
    logic [DW-1:0] mem_rdata  [2];

    cache_lookup_ctrl #(.WRITE_BACK(1)) u_cache_lookup_ctrl (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid[0]), .req_write(req_write[0]), .req_addr(req_addr[0]),
        .req_wdata(req_wdata[0]), .req_ready(req_ready[0]), .resp_valid(resp_valid[0]),
        .resp_rdata(resp_rdata[0]), .resp_hit(resp_hit[0]), .victim_way(victim_way[0]),
        .mem_req(mem_req[0]), .mem_we(mem_we[0]), .mem_addr(mem_addr[0]),
        .mem_wdata(mem_wdata[0]), .mem_ack(mem_ack[0]), .mem_rdata(mem_rdata[0])
    );

    cache_lookup_ctrl #(.WRITE_BACK(0)) u_cache_lookup_ctrl_wt (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid[1]), .req_write(req_write[1]), .req_addr(req_addr[1]),
        .req_wdata(req_wdata[1]), .req_ready(req_ready[1]), .resp_valid(resp_valid[1]),
        .resp_rdata(resp_rdata[1]), .resp_hit(resp_hit[1]), .victim_way(victim_way[1]),
        .mem_req(mem_req[1]), .mem_we(mem_we[1]), .mem_addr(mem_addr[1]),
        .mem_wdata(mem_wdata[1]), .mem_ack(mem_ack[1]), .mem_rdata(mem_rdata[1])
    );

    cache_mem_model u_mem_wb (
        .clk(clk), .mem_req(mem_req[0]), .mem_we(mem_we[0]), .mem_addr(mem_addr[0]),
        .mem_wdata(mem_wdata[0]), .mem_ack(mem_ack[0]), .mem_rdata(mem_rdata[0])
    );

    cache_mem_model u_mem_wt (
        .clk(clk), .mem_req(mem_req[1]), .mem_we(mem_we[1]), .mem_addr(mem_addr[1]),
        .mem_wdata(mem_wdata[1]), .mem_ack(mem_ack[1]), .mem_rdata(mem_rdata[1])
    );

    int checks = 0;
    int errors = 0;
    int cyc    = 0;
    logic          done = 1'b0;
    logic [DW-1:0] gmem [2][1 << AW];
    int            mtag [2][SETS][WAYS];
    bit            mval [2][SETS][WAYS];
    int            age  [2][SETS][WAYS];

    always @(posedge clk) cyc++;

    function automatic logic [DW-1:0] seed_word(input int a);
        return DW'(32'(a) * 32'h9E3779B1 ^ 32'h5A5A0000);
    endfunction

    function automatic int wr_cnt(input int m);
        return (m == 0) ? u_mem_wb.wr_count : u_mem_wt.wr_count;
    endfunction

    function automatic int rd_cnt(input int m);
        return (m == 0) ? u_mem_wb.rd_count : u_mem_wt.rd_count;
    endfunction

    function automatic logic [DW-1:0] mem_word(input int m, input int a);
        return (m == 0) ? u_mem_wb.store[a] : u_mem_wt.store[a];
    endfunction

    task automatic check(input bit ok, input string req, input logic [DW-1:0] act,
                         input logic [DW-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic touch(input int m, input int s, input int w);
        for (int k = 0; k < WAYS; k++) age[m][s][k]++;
        age[m][s][w] = 0;
    endtask

    task automatic access(input int m, input logic we, input int a, input logic [DW-1:0] wd,
                          input string req, output logic got_hit, output logic [DW-1:0] got_data);
        int  s, t, pw, vic, cycles;
        bit  ph, ready_bad;
        s  = (a >> OFF_W) % SETS;
        t  = a >> (OFF_W + SET_W);
        ph = 0; pw = 0;
        for (int w = 0; w < WAYS; w++)
            if (mval[m][s][w] && mtag[m][s][w] == t) begin ph = 1; pw = w; end
        vic = 0;
        for (int w = 1; w < WAYS; w++) if (age[m][s][w] > age[m][s][vic]) vic = w;
        req_valid[m]  = 1'b1;
        req_write[m]  = we;
        req_addr[m]   = AW'(a);
        req_wdata[m]  = wd;
        victim_way[m] = 1'(vic);
        @(negedge clk);
        req_valid[m] = 1'b0;
        cycles = 0; ready_bad = 0;
        while (!resp_valid[m] && cycles < 400) begin
            if (req_ready[m]) ready_bad = 1;
            @(negedge clk);
            cycles++;
        end
        check(cycles < 400, "R5 response timeout", DW'(cycles), 32'd400);
        check(!ready_bad && req_ready[m], "R5 ready low while busy", DW'(ready_bad), 32'd0);
        got_hit  = resp_hit[m];
        got_data = resp_rdata[m];
        check(got_hit == ph, {req, " hit flag"}, DW'(got_hit), DW'(ph));
        if (!we) check(got_data == gmem[m][a], {req, " read data"}, got_data, gmem[m][a]);
        if (ph) touch(m, s, pw);
        else if (!(we && m == 1)) begin
            mval[m][s][vic] = 1; mtag[m][s][vic] = t; touch(m, s, vic);
        end
        if (we) gmem[m][a] = wd;
        @(negedge clk);
        check(!resp_valid[m], "R5 one-cycle response", DW'(resp_valid[m]), 32'd0);
    endtask

    initial begin : watchdog
        wait (cyc >= 150000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog R5 actual=%0d expected<150000", cyc);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin : main
        logic          h;
        logic [DW-1:0] d;
        int            r0, w0;
        logic [DW-1:0] x1, x2, x3;
        void'($urandom(32'd1234));
        for (int m = 0; m < 2; m++) begin
            req_valid[m] = 0; req_write[m] = 0; req_addr[m] = '0;
            req_wdata[m] = '0; victim_way[m] = '0;
            for (int a = 0; a < (1 << AW); a++) gmem[m][a] = seed_word(a);
            for (int s = 0; s < SETS; s++)
                for (int w = 0; w < WAYS; w++) begin
                    mval[m][s][w] = 0; mtag[m][s][w] = 0; age[m][s][w] = 0;
                end
        end
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R2 reset state on both instances
        for (int m = 0; m < 2; m++) begin
            check(req_ready[m] == 1'b1, "R2 ready after reset", DW'(req_ready[m]), 32'd1);
            check(resp_valid[m] == 1'b0, "R2 no response after reset", DW'(resp_valid[m]), 32'd0);
            check(mem_req[m] == 1'b0, "R2 memory idle after reset", DW'(mem_req[m]), 32'd0);
        end

        // R12 conflict trace in set 0 with LRU victims, plus R4 refill count
        r0 = rd_cnt(0); w0 = wr_cnt(0);
        access(0, 0, 0, '0, "R12 trace", h, d);
        check(h == 0, "R12 trace access0 miss (R2 cold)", DW'(h), 32'd0);
        check(rd_cnt(0) - r0 == WORDS && wr_cnt(0) == w0, "R4 refill word count",
              DW'(rd_cnt(0) - r0), DW'(WORDS));
        access(0, 0, 1, '0, "R1 same line", h, d);
        check(h == 1, "R1 offset-only change hits", DW'(h), 32'd1);
        access(0, 0, 49, '0, "R12 trace", h, d);
        check(h == 0, "R12 trace access 49 miss", DW'(h), 32'd0);
        access(0, 0, 32, '0, "R12 trace", h, d);
        check(h == 0, "R12 trace access 32 miss", DW'(h), 32'd0);
        access(0, 0, 0, '0, "R12 trace", h, d);
        check(h == 0, "R12 trace final access0 miss", DW'(h), 32'd0);

        // R7 write hit stays in cache
        x1 = 32'hDEAD0001;
        w0 = wr_cnt(0);
        access(0, 1, 0, x1, "R7 write hit", h, d);
        check(h == 1, "R7 write hits", DW'(h), 32'd1);
        check(wr_cnt(0) == w0 && mem_word(0, 0) == seed_word(0), "R7 memory untouched",
              mem_word(0, 0), seed_word(0));
        access(0, 0, 0, '0, "R7 read back", h, d);
        check(d == x1, "R7 new word read", d, x1);

        // R8 clean victim then dirty victim
        w0 = wr_cnt(0);
        access(0, 0, 49, '0, "R8 clean evict", h, d);
        check(wr_cnt(0) == w0, "R8 clean victim no write-back", DW'(wr_cnt(0) - w0), 32'd0);
        access(0, 0, 16, '0, "R8 dirty evict", h, d);
        check(wr_cnt(0) - w0 == WORDS, "R8 dirty victim words written",
              DW'(wr_cnt(0) - w0), DW'(WORDS));
        check(mem_word(0, 0) == x1, "R8 written-back word in memory", mem_word(0, 0), x1);

        // R9 write miss allocates
        x2 = 32'hBEEF0064;
        r0 = rd_cnt(0);
        access(0, 1, 100, x2, "R9 write miss", h, d);
        check(h == 0 && rd_cnt(0) - r0 == WORDS, "R9 write miss refills",
              DW'(rd_cnt(0) - r0), DW'(WORDS));
        access(0, 0, 100, '0, "R9 read after allocate", h, d);
        check(h == 1 && d == x2, "R9 allocated line hits", d, x2);

        // R10 write-through write hit
        access(1, 0, 5, '0, "R10 prime", h, d);
        x3 = 32'hCAFE0005;
        w0 = wr_cnt(1); r0 = rd_cnt(1);
        access(1, 1, 5, x3, "R10 write hit", h, d);
        check(wr_cnt(1) - w0 == 1 && rd_cnt(1) == r0, "R10 one word write",
              DW'(wr_cnt(1) - w0), 32'd1);
        check(mem_word(1, 5) == x3, "R10 memory updated", mem_word(1, 5), x3);
        access(1, 0, 5, '0, "R10 cached copy", h, d);
        check(h == 1 && d == x3, "R10 cached copy updated", d, x3);

        // R11 write-through write miss
        w0 = wr_cnt(1); r0 = rd_cnt(1);
        access(1, 1, 200, 32'h0BAD00C8, "R11 write miss", h, d);
        check(h == 0 && wr_cnt(1) - w0 == 1 && rd_cnt(1) == r0, "R11 write around",
              DW'(rd_cnt(1) - r0), 32'd0);
        check(mem_word(1, 200) == 32'h0BAD00C8, "R11 memory word", mem_word(1, 200), 32'h0BAD00C8);
        access(1, 0, 200, '0, "R11 no allocation", h, d);
        check(h == 0, "R11 later read misses", DW'(h), 32'd0);

        // random mix in both modes (R3 R4 R7 R8 R9 R10 R11)
        for (int i = 0; i < 300; i++) begin
            for (int m = 0; m < 2; m++) begin
                access(m, 1'($urandom % 2), int'($urandom % 256), $urandom,
                       (m == 0) ? "R3 random write-back" : "R3 random write-through", h, d);
            end
        end

        check(u_mem_wb.viol == 0, "R6 handshake hold (write-back)", DW'(u_mem_wb.viol), 32'd0);
        check(u_mem_wt.viol == 0, "R6 handshake hold (write-through)", DW'(u_mem_wt.viol), 32'd0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule